// File: doc/BRIEF.md
# System Configuration Register Controller

This block is a memory-mapped bank of control registers on a simple 32-bit read/write port. It holds two general-purpose configuration words. The low byte of the second word drives eight LED outputs. It also has two read-only identification words that are set by parameters, and a DLL status word. In the DLL word, a writable enable mask chooses which of the eight live lock inputs must be asserted before the summary "all locked" bit reads as one.

A small bank of oscillator-frequency registers is not directly addressable. Software reaches it through an indirect channel built from four registers: an outgoing-data register, a return-data register, a control register and a status register. Software writes a control word that names a function code, a device index and a direction, with the launch bit set. The transaction then completes on the same clock edge. It moves a value from the outgoing-data register into an oscillator register, or from an oscillator register into the return-data register. The status register reports completion and whether the request was rejected.

Reads are combinational from the address while `bus_sel` is high and `bus_wr` is low. Writes take effect on the rising clock edge.

Top module: `sysreg_ctrl`

## Requirements
- R1: The control register (offset 0xA8) keeps bits [11:0] (device), [25:20] (function) and [30] (1 = write, 0 = read). Bits [19:12], [29:26] and the launch bit [31] are never stored and always read as zero.
- R2: Every write to the control register clears the status register (offset 0xAC) when the launch bit is zero.
- R3: A control write with bit 31 set makes status bit 0 (done) read 1 on the next cycle. Status bit 1 (error) is set with it when the request is illegal.
- R4: A request is legal only when the function field equals 1 and the device index is below the oscillator count (default 3).
- R5: A legal write request copies the outgoing-data register (offset 0xA4) into the selected oscillator register.
- R6: A legal read request loads the selected oscillator register into the return-data register (offset 0xA0).
- R7: An illegal request changes neither the oscillator registers nor the return-data register.
- R8: After reset, the oscillators hold 50000000, 24576000 and 25000000, and the control register reads 0x00100000. The status, return-data, outgoing-data and general registers read 0, and the DLL mask reads 0xFF.
- R9: The DLL word (offset 0x08) reads {mask[7:0], lock_in[7:0], 15'b0, all}. Only bits [31:24] are writable. `all` is 1 when every lock input whose mask bit is 1 is asserted.
- R10: `led` equals bits [7:0] of the second general register (offset 0x04). The first general register is at 0x00.
- R11: The identification words (0x0C, 0x10) read their parameter values and ignore writes. Undecoded offsets read zero, and writes to them have no effect.
- R12: A request completes with no busy state: its results are readable in the cycle right after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when not reading) |
| dll_lock_in | input | 8 | Per-DLL lock flags |
| led | output | 8 | LED drive |

## Verification
A corrupted oscillator register stays hidden until a legal read request copies it into the return-data register. It then shows up on the next read of offset 0xA0, one cycle after the launching control write. A wrong legality decision shows up one cycle after launch, either in status bit 1 or as an unexpected change to the return or oscillator values. A status register that fails to clear, or a stored reserved control bit, shows up on the first read of that register after the control write.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam logic [11:0] OFF_GEN0  = 12'h000;
  localparam logic [11:0] OFF_GEN1  = 12'h004;
  localparam logic [11:0] OFF_DLL   = 12'h008;
  localparam logic [11:0] OFF_IDA   = 12'h00C;
  localparam logic [11:0] OFF_IDB   = 12'h010;
  localparam logic [11:0] OFF_RTN   = 12'h0A0;
  localparam logic [11:0] OFF_OUT   = 12'h0A4;
  localparam logic [11:0] OFF_CTRL  = 12'h0A8;
  localparam logic [11:0] OFF_STAT  = 12'h0AC;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h43F0_0FFF;
  localparam logic [31:0] CTRL_RESET     = 32'h0010_0000;
  localparam logic [5:0]  FN_OSC         = 6'd1;

  typedef struct packed {
    logic gen0;
    logic gen1;
    logic dll;
    logic ida;
    logic idb;
    logic rtn;
    logic outd;
    logic ctrl;
    logic stat;
  } reg_hit_t;

  // Reset frequency of oscillator idx
  function automatic logic [31:0] osc_reset(input int idx);
    case (idx)
      0:       return 32'd50_000_000;
      1:       return 32'd24_576_000;
      2:       return 32'd25_000_000;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic chan_legal(input logic [5:0] fn,
                                      input logic [11:0] dev,
                                      input int num_osc);
    return (fn == FN_OSC) && (int'(dev) < num_osc);
  endfunction

  function automatic logic [31:0] ctrl_clean(input logic [31:0] w);
    return w & CTRL_KEEP_MASK;
  endfunction

  function automatic logic dll_all_locked(input logic [7:0] lock,
                                          input logic [7:0] mask);
    return &(lock | ~mask);
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  localparam int PAD = 12 - ADDR_W;
  logic [11:0] a;

  generate
    if (ADDR_W >= 12) begin : g_trunc
      assign a = addr[11:0];
    end else begin : g_pad
      assign a = {{PAD{1'b0}}, addr};
    end
  endgenerate

  always_comb begin
    hit      = '0;
    hit.gen0 = (a == OFF_GEN0);
    hit.gen1 = (a == OFF_GEN1);
    hit.dll  = (a == OFF_DLL);
    hit.ida  = (a == OFF_IDA);
    hit.idb  = (a == OFF_IDB);
    hit.rtn  = (a == OFF_RTN);
    hit.outd = (a == OFF_OUT);
    hit.ctrl = (a == OFF_CTRL);
    hit.stat = (a == OFF_STAT);
  end
endmodule

// File: rtl/sysreg_dll.sv
module sysreg_dll
  import sysreg_pkg::*;
#(
  parameter int NUM_DLL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr,
  input  logic [NUM_DLL-1:0] mask_wdata,
  input  logic [NUM_DLL-1:0] lock_in,
  output logic [NUM_DLL-1:0] mask_q,
  output logic               all_locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign all_locked = dll_all_locked(lock_in, mask_q);
endmodule

// File: rtl/sysreg_chan.sv
module sysreg_chan
  import sysreg_pkg::*;
#(
  parameter int NUM_OSC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        out_wr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q,
  output logic [1:0]  stat_q,
  output logic [31:0] rtn_q,
  output logic [31:0] out_q,
  output logic        ev_start,
  output logic        ev_illegal,
  output logic        ev_osc_upd,
  output logic        ev_rtn_upd
);
  logic [11:0] req_dev;
  logic [5:0]  req_fn;
  logic        req_we;
  logic        req_ok;
  logic [31:0] osc_q [NUM_OSC];
  logic [31:0] osc_sel;

  assign req_dev    = wdata[11:0];
  assign req_fn     = wdata[25:20];
  assign req_we     = wdata[30];
  assign ev_start   = ctrl_wr & wdata[31];
  assign req_ok     = chan_legal(req_fn, req_dev, NUM_OSC);
  assign ev_illegal = ev_start & ~req_ok;
  assign ev_osc_upd = ev_start & req_ok & req_we;
  assign ev_rtn_upd = ev_start & req_ok & ~req_we;

  genvar g;
  generate
    for (g = 0; g < NUM_OSC; g++) begin : g_osc
      always_ff @(posedge clk) begin
        if (!rst_n)
          osc_q[g] <= osc_reset(g);
        else if (ev_osc_upd && req_dev == 12'(g))
          osc_q[g] <= out_q;
      end
    end
  endgenerate

  always_comb begin
    osc_sel = '0;
    for (int i = 0; i < NUM_OSC; i++)
      if (req_dev == 12'(i)) osc_sel = osc_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      stat_q <= '0;
      rtn_q  <= '0;
      out_q  <= '0;
    end else begin
      if (out_wr) out_q <= wdata;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_clean(wdata);
        stat_q <= ev_start ? {~req_ok, 1'b1} : 2'b00;
      end
      if (ev_rtn_upd) rtn_q <= osc_sel;
    end
  end
endmodule

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          NUM_OSC  = 3,
  parameter int          NUM_DLL  = 8,
  parameter int          NUM_LED  = 8,
  parameter logic [31:0] ID_A_VAL = 32'h0000_5A01,
  parameter logic [31:0] ID_B_VAL = 32'h4100_0C21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_DLL-1:0] dll_lock_in,
  output logic [NUM_LED-1:0] led
);
  localparam int DLL_MSB = 24 + NUM_DLL - 1;

  reg_hit_t           hit;
  logic               wr_en, rd_en;
  logic               gen0_wr, gen1_wr, dll_wr, ctrl_wr, out_wr;
  logic [31:0]        gen0_q, gen1_q;
  logic [31:0]        ctrl_q, rtn_q, out_q;
  logic [1:0]         stat_q;
  logic [NUM_DLL-1:0] dll_mask_q;
  logic               dll_all;
  logic [31:0]        dll_word;
  logic               ev_start, ev_illegal, ev_osc_upd, ev_rtn_upd;

  sysreg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign gen0_wr = wr_en & hit.gen0;
  assign gen1_wr = wr_en & hit.gen1;
  assign dll_wr  = wr_en & hit.dll;
  assign ctrl_wr = wr_en & hit.ctrl;
  assign out_wr  = wr_en & hit.outd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen0_q <= '0;
      gen1_q <= '0;
    end else begin
      if (gen0_wr) gen0_q <= bus_wdata;
      if (gen1_wr) gen1_q <= bus_wdata;
    end
  end

  assign led = gen1_q[NUM_LED-1:0];

  sysreg_dll #(.NUM_DLL(NUM_DLL)) u_dll (
    .clk(clk), .rst_n(rst_n), .mask_wr(dll_wr),
    .mask_wdata(bus_wdata[DLL_MSB:24]), .lock_in(dll_lock_in),
    .mask_q(dll_mask_q), .all_locked(dll_all)
  );

  always_comb begin
    dll_word              = '0;
    dll_word[DLL_MSB:24]  = dll_mask_q;
    dll_word[16+NUM_DLL-1:16] = dll_lock_in;
    dll_word[0]           = dll_all;
  end

  sysreg_chan #(.NUM_OSC(NUM_OSC)) u_chan (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .out_wr(out_wr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q), .rtn_q(rtn_q),
    .out_q(out_q), .ev_start(ev_start), .ev_illegal(ev_illegal),
    .ev_osc_upd(ev_osc_upd), .ev_rtn_upd(ev_rtn_upd)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (1'b1)
        hit.gen0: bus_rdata = gen0_q;
        hit.gen1: bus_rdata = gen1_q;
        hit.dll:  bus_rdata = dll_word;
        hit.ida:  bus_rdata = ID_A_VAL;
        hit.idb:  bus_rdata = ID_B_VAL;
        hit.rtn:  bus_rdata = rtn_q;
        hit.outd: bus_rdata = out_q;
        hit.ctrl: bus_rdata = ctrl_q;
        hit.stat: bus_rdata = {30'd0, stat_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_ctrl_chk.sv
module sysreg_ctrl_chk #(
  parameter int NUM_LED = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_wr,
  input logic               ev_start,
  input logic               ev_illegal,
  input logic [1:0]         stat_q,
  input logic [31:0]        rtn_q,
  input logic               gen1_wr,
  input logic [NUM_LED-1:0] led,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               ctrl_hit,
  input logic [31:0]        bus_rdata
);
  assert_ctrl_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ctrl_hit) |-> (bus_rdata & 32'hBC0F_F000) == 32'd0);

  assert_stat_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ev_start) |=> stat_q == 2'b00);

  assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> stat_q[0]);

  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> stat_q[1]);

  assert_rtn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> $stable(rtn_q));

  assert_led_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen1_wr |=> $stable(led));
endmodule

bind sysreg_ctrl sysreg_ctrl_chk #(.NUM_LED(NUM_LED)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ev_start(ev_start),
  .ev_illegal(ev_illegal), .stat_q(stat_q), .rtn_q(rtn_q),
  .gen1_wr(gen1_wr), .led(led), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .ctrl_hit(hit.ctrl), .bus_rdata(bus_rdata)
);

// File: tb/sysreg_ctrl_bench.sv
module sysreg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  dll_lock_in = 8'h00;
  logic [7:0]  led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  sysreg_ctrl u_sysreg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dll_lock_in(dll_lock_in), .led(led)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: samples 1 ns before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (bus_sel && !bus_wr && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_rdata, e.exp, e.tag);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(negedge clk);
    sb_q.push_back(e);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  // Launch a request: fn, dev, we; bit 31 set
  function automatic logic [31:0] req(input logic [5:0] fn, input logic [11:0] dev, input bit we);
    return {1'b1, we, 4'b0, fn, 8'b0, dev};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    rd(12'h0A8, 32'h0010_0000, "R8 ctrl reset");
    rd(12'h0AC, 32'h0,         "R8 stat reset");
    rd(12'h0A0, 32'h0,         "R8 rtn reset");
    rd(12'h000, 32'h0,         "R8 gen0 reset");
    checks++; if (led !== 8'h00) begin errors++; $display("FAIL R8 led actual=%02h expected=00", led); end
    dll_lock_in = 8'hFF;
    rd(12'h008, 32'hFFFF_0001, "R8 R9 dll reset mask");
    // Oscillator reset values via legal reads (R6, R12)
    wr(12'h0A8, req(6'd1, 12'd0, 0));
    rd(12'h0A0, 32'd50_000_000, "R8 R12 osc0");
    rd(12'h0AC, 32'h1,          "R3 done legal read");
    wr(12'h0A8, req(6'd1, 12'd1, 0));
    rd(12'h0A0, 32'd24_576_000, "R6 osc1");
    wr(12'h0A8, req(6'd1, 12'd2, 0));
    rd(12'h0A0, 32'd25_000_000, "R6 osc2");
    // R1 reserved fields dropped
    wr(12'h0A8, 32'h7FFF_FFFF);
    rd(12'h0A8, 32'h43F0_0FFF, "R1 ctrl readback");
    // R2 clear status
    wr(12'h0A8, req(6'd2, 12'd0, 0));
    rd(12'h0AC, 32'h3, "R3 R4 bad function error");
    wr(12'h0A8, 32'h0000_0001);
    rd(12'h0AC, 32'h0, "R2 status cleared");
    // R5 legal write then read back
    wr(12'h0A4, 32'h1234_5678);
    rd(12'h0A4, 32'h1234_5678, "R5 outdata readback");
    wr(12'h0A8, req(6'd1, 12'd1, 1));
    rd(12'h0AC, 32'h1, "R5 write done");
    wr(12'h0A8, req(6'd1, 12'd1, 0));
    rd(12'h0A0, 32'h1234_5678, "R5 osc1 updated");
    // R4 boundary: device 3 illegal, R7 nothing changes
    wr(12'h0A4, 32'hDEAD_BEEF);
    wr(12'h0A8, req(6'd1, 12'd3, 1));
    rd(12'h0AC, 32'h3, "R4 dev=3 error");
    wr(12'h0A8, req(6'd1, 12'd3, 0));
    rd(12'h0A0, 32'h1234_5678, "R7 rtn unchanged");
    wr(12'h0A8, req(6'd0, 12'd2, 1));
    rd(12'h0AC, 32'h3, "R4 fn=0 error");
    wr(12'h0A8, req(6'd1, 12'd2, 0));
    rd(12'h0A0, 32'd25_000_000, "R7 osc2 unchanged");
    wr(12'h0A8, req(6'd1, 12'd0, 0));
    rd(12'h0A0, 32'd50_000_000, "R7 osc0 unchanged");
    // R9 DLL
    wr(12'h008, 32'h0F00_FFFF);
    dll_lock_in = 8'h0F;
    rd(12'h008, 32'h0F0F_0001, "R9 masked all locked");
    dll_lock_in = 8'h07;
    rd(12'h008, 32'h0F07_0000, "R9 unmasked dll unlocked");
    dll_lock_in = 8'hF0;
    wr(12'h008, 32'h0000_0000);
    rd(12'h008, 32'h00F0_0001, "R9 empty mask");
    // R10 LEDs and general regs
    wr(12'h004, 32'hABCD_00A5);
    @(negedge clk);
    checks++; if (led !== 8'hA5) begin errors++; $display("FAIL R10 led actual=%02h expected=a5", led); end
    rd(12'h004, 32'hABCD_00A5, "R10 gen1 readback");
    wr(12'h000, 32'h5555_AAAA);
    rd(12'h000, 32'h5555_AAAA, "R10 gen0 readback");
    // R11 ID regs and undecoded
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h0000_5A01, "R11 id a read-only");
    rd(12'h010, 32'h4100_0C21, "R11 id b");
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, 32'h0, "R11 undecoded read zero");
    rd(12'h004, 32'hABCD_00A5, "R11 undecoded write ignored");
    rd(12'h0A4, 32'hDEAD_BEEF, "R11 outdata intact");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard left=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule